// File: doc/BRIEF.md
# EX-Stage Operand Forwarding and Load-Use Hazard Unit

This unit resolves read-after-write data hazards for a five-stage in-order pipeline. The instruction in decode presents its two source register numbers. The unit compares them with the destinations of the older instructions that are still in flight. From that comparison it sets up, one cycle ahead, the two EX-stage operand multiplexer selects. Each select chooses the register-file value, the ALU result held in the EX/MEM register, or the final write-back value held in MEM/WB. When two older producers write the same register, the younger one wins.

The unit also watches the instruction in EX. If that instruction is a load and the decode instruction needs its destination, forwarding cannot help: the loaded data only exists after the memory stage. The unit therefore raises a stall request in the same cycle. The pipeline then holds PC and IF/ID and places a bubble into ID/EX. One cycle later the load result is picked up from MEM/WB.

A decode-stage read of a register that write-back is writing in the same cycle is flagged per operand, so the register-file output can be bypassed. Parameter `RF_SPLIT_PHASE` selects an equivalent arrangement instead. In that mode the register file writes in the first half-cycle and reads in the second, and the bypass flags stay low.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both operand selects are 00 (register file) after that edge.
- R2: The select encoding per operand is 00 register file, 10 EX/MEM ALU result, 01 MEM/WB write-back value; 11 is never produced.
- R3: If a decode source equals the ID/EX destination, that stage writes a register and there is no stall, that operand's select is 10 in the following cycle.
- R4: If a decode source equals the EX/MEM destination with its write enable set, and does not match a writing ID/EX destination, that operand's select is 01 in the following cycle.
- R5: When both older stages match the same source, the select is 10 in the following cycle, so the more recent producer wins.
- R6: Register 0 is never forwarded, never bypassed and never causes a stall.
- R7: A stage whose write enable is low never causes a forward, a bypass or a stall, even when its destination matches.
- R8: `stall` is high in the same cycle when ID/EX holds a writing load (`idex_mem_rd` high) whose nonzero destination equals either decode source. After a stalled cycle, both selects are 00.
- R9: After one stall cycle the load sits in EX/MEM with ID/EX empty, and the held decode instruction then gets select 01 for each operand that reads the load destination.
- R10: With `RF_SPLIT_PHASE` = 0, `rf_byp_a`/`rf_byp_b` are high in the same cycle when the matching decode source is nonzero and equals the MEM/WB destination with its write enable set.
- R11: With `RF_SPLIT_PHASE` = 1, both bypass flags stay low for all inputs.
- R12: The two operands are decided independently; each select depends only on its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| idex_rd | input | REG_W | Destination of the instruction in EX |
| idex_we | input | 1 | Instruction in EX writes a register |
| idex_mem_rd | input | 1 | Instruction in EX is a load |
| exmem_rd | input | REG_W | Destination of the instruction in MEM |
| exmem_we | input | 1 | Instruction in MEM writes a register |
| memwb_rd | input | REG_W | Destination of the instruction in WB |
| memwb_we | input | 1 | Instruction in WB writes a register |
| fwd_a_sel | output | 2 | Registered EX operand A source select |
| fwd_b_sel | output | 2 | Registered EX operand B source select |
| stall | output | 1 | Load-use stall request for the current cycle |
| rf_byp_a | output | 1 | Decode read of operand A takes the write-back value |
| rf_byp_b | output | 1 | Decode read of operand B takes the write-back value |

## Verification
`stall` and the two bypass flags are combinational and are due in the cycle the stage fields are presented. The bench drives at the falling edge and checks them half a nanosecond later. The operand selects are registered, so they are due one edge after the decode fields. The bench keeps a pending expectation and compares it at the next falling edge, before the next stimulus is applied. Directed sequences cover the three-deep chain to one register and the two-cycle load-use pattern. A second instance in split-phase mode checks that the bypass flags stay low.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Chooses the source of one EX operand for the next cycle.
// The ID/EX producer moves to EX/MEM and the EX/MEM producer moves to MEM/WB.
module fwd_operand_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_we,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_we,
  output fwd_pkg::fwd_sel_e sel_next
);
  import fwd_pkg::*;
  logic nz, hit_young, hit_old;

  always_comb begin
    nz        = (src != '0);
    hit_young = nz && idex_we  && (idex_rd  == src);
    hit_old   = nz && exmem_we && (exmem_rd == src);
    if (hit_young)    sel_next = SEL_EXMEM;
    else if (hit_old) sel_next = SEL_MEMWB;
    else              sel_next = SEL_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
// Flags a decode instruction that needs the result of a load now in EX.
module load_use_detect #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcs,
  input  logic [REG_W-1:0]              ld_rd,
  input  logic                          ld_we,
  input  logic                          ld_is_load,
  output logic                          hit
);
  logic [NUM_SRC-1:0] per_src;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign per_src[i] = (srcs[i] != '0) && (srcs[i] == ld_rd);
  end

  assign hit = ld_is_load && ld_we && (|per_src);
endmodule

// File: rtl/rf_bypass_sel.sv
// Same-cycle write-back to decode-read bypass for one operand.
module rf_bypass_sel #(
  parameter int REG_W          = 5,
  parameter bit RF_SPLIT_PHASE = 1'b0
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic             byp
);
  localparam bit USE_BYP = !RF_SPLIT_PHASE;
  logic match;

  assign match = wb_we && (src != '0) && (src == wb_rd);
  assign byp   = USE_BYP && match;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W          = 5,
  parameter bit RF_SPLIT_PHASE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_we,
  input  logic             idex_mem_rd,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_we,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             stall,
  output logic             rf_byp_a,
  output logic             rf_byp_b
);
  import fwd_pkg::*;
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
  fwd_sel_e [NUM_SRC-1:0]        sel_next;
  fwd_sel_e [NUM_SRC-1:0]        sel_q;
  logic [NUM_SRC-1:0]            byp_vec;
  logic                          lu_hit;

  assign src_vec[0] = id_rs1;
  assign src_vec[1] = id_rs2;

  load_use_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lud (
    .srcs       (src_vec),
    .ld_rd      (idex_rd),
    .ld_we      (idex_we),
    .ld_is_load (idex_mem_rd),
    .hit        (lu_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    fwd_operand_sel #(.REG_W(REG_W)) u_sel (
      .src      (src_vec[i]),
      .idex_rd  (idex_rd),
      .idex_we  (idex_we),
      .exmem_rd (exmem_rd),
      .exmem_we (exmem_we),
      .sel_next (sel_next[i])
    );

    rf_bypass_sel #(.REG_W(REG_W), .RF_SPLIT_PHASE(RF_SPLIT_PHASE)) u_byp (
      .src   (src_vec[i]),
      .wb_rd (memwb_rd),
      .wb_we (memwb_we),
      .byp   (byp_vec[i])
    );

    // A stalled cycle sends a bubble into EX, which needs no forwarding.
    always_ff @(posedge clk) begin
      if (rst || lu_hit) sel_q[i] <= SEL_RF;
      else               sel_q[i] <= sel_next[i];
    end
  end

  assign fwd_a_sel = sel_q[0];
  assign fwd_b_sel = sel_q[1];
  assign stall     = lu_hit;
  assign rf_byp_a  = byp_vec[0];
  assign rf_byp_b  = byp_vec[1];
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic [REG_W-1:0] idex_rd,
  input logic             idex_we,
  input logic [REG_W-1:0] exmem_rd,
  input logic             exmem_we,
  input logic [REG_W-1:0] memwb_rd,
  input logic             memwb_we,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             stall,
  input logic             rf_byp_a,
  input logic             rf_byp_b
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  p_enc_r2: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11));

  p_young_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && idex_we && id_rs1 != '0 && idex_rd == id_rs1) |=> fwd_a_sel == 2'b10);

  p_old_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!stall && exmem_we && id_rs2 != '0 && exmem_rd == id_rs2 &&
     !(idex_we && idex_rd == id_rs2)) |=> fwd_b_sel == 2'b01);

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0) |=> fwd_a_sel == 2'b00);

  p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  p_stall_we_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> idex_we);

  p_byp_r10: assert property (@(posedge clk) disable iff (rst)
    rf_byp_a |-> (memwb_we && memwb_rd == id_rs1 && id_rs1 != '0));

  p_byp_b_r10: assert property (@(posedge clk) disable iff (rst)
    rf_byp_b |-> (memwb_we && memwb_rd == id_rs2 && id_rs2 != '0));
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .idex_rd(idex_rd), .idex_we(idex_we), .exmem_rd(exmem_rd), .exmem_we(exmem_we),
  .memwb_rd(memwb_rd), .memwb_we(memwb_we), .fwd_a_sel(fwd_a_sel),
  .fwd_b_sel(fwd_b_sel), .stall(stall), .rf_byp_a(rf_byp_a), .rf_byp_b(rf_byp_b)
);

// File: tb/fwd_hazard_unit_tb.sv
`timescale 1ns/100ps
module fwd_hazard_unit_tb;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] id_rs1 = '0, id_rs2 = '0, idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
  logic idex_we = 1'b0, idex_mem_rd = 1'b0, exmem_we = 1'b0, memwb_we = 1'b0;
  logic [1:0] fa, fb, sfa, sfb;
  logic st, ba, bb, sst, sba, sbb;

  int checks = 0;
  int errors = 0;
  logic [1:0] pend_a = 2'b00, pend_b = 2'b00;
  bit have_pend = 1'b0;

  always #2 clk = ~clk;

  fwd_hazard_unit #(.REG_W(REG_W), .RF_SPLIT_PHASE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_mem_rd(idex_mem_rd),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .fwd_a_sel(fa), .fwd_b_sel(fb), .stall(st), .rf_byp_a(ba), .rf_byp_b(bb)
  );

  fwd_hazard_unit #(.REG_W(REG_W), .RF_SPLIT_PHASE(1'b1)) u_dut_split (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_mem_rd(idex_mem_rd),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .fwd_a_sel(sfa), .fwd_b_sel(sfb), .stall(sst), .rf_byp_a(sba), .rf_byp_b(sbb)
  );

  function automatic logic [1:0] model_sel(logic [REG_W-1:0] s);
    if (s != 0 && idex_we && idex_rd == s)   return 2'b10;
    if (s != 0 && exmem_we && exmem_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic model_stall();
    return idex_mem_rd && idex_we && idex_rd != 0 &&
           (idex_rd == id_rs1 || idex_rd == id_rs2);
  endfunction

  function automatic logic model_byp(logic [REG_W-1:0] s);
    return memwb_we && s != 0 && memwb_rd == s;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(bit r, logic [REG_W-1:0] a, logic [REG_W-1:0] b,
                      logic [REG_W-1:0] ir, bit iw, bit im,
                      logic [REG_W-1:0] er, bit ew,
                      logic [REG_W-1:0] wr, bit ww, string tag);
    @(negedge clk);
    if (have_pend) begin
      check({tag, " sel_a R2/R12"}, fa, pend_a);
      check({tag, " sel_b R2/R12"}, fb, pend_b);
      check({tag, " split sel_a"}, sfa, pend_a);
    end
    rst = r; id_rs1 = a; id_rs2 = b; idex_rd = ir; idex_we = iw; idex_mem_rd = im;
    exmem_rd = er; exmem_we = ew; memwb_rd = wr; memwb_we = ww;
    #0.5;
    if (!r) begin
      check({tag, " stall R8"}, {1'b0, st}, {1'b0, model_stall()});
      check({tag, " byp_a R10"}, {1'b0, ba}, {1'b0, model_byp(a)});
      check({tag, " byp_b R10"}, {1'b0, bb}, {1'b0, model_byp(b)});
      check({tag, " split byp R11"}, {sba, sbb}, 2'b00);
    end
    if (r || model_stall()) begin
      pend_a = 2'b00; pend_b = 2'b00;
    end else begin
      pend_a = model_sel(a); pend_b = model_sel(b);
    end
    have_pend = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset with matching fields present
    step(1, 3, 3, 3, 1, 0, 3, 1, 3, 1, "R1 reset");
    step(1, 3, 3, 3, 1, 0, 3, 1, 3, 1, "R1 reset");
    // R3 young producer only
    step(0, 4, 7, 4, 1, 0, 9, 1, 0, 0, "R3");
    // R4 old producer only
    step(0, 9, 4, 2, 1, 0, 4, 1, 0, 0, "R4");
    // R5 chain to r1 three deep (also bypass R10)
    step(0, 1, 1, 1, 1, 0, 1, 1, 1, 1, "R5 chain");
    // R6 register zero everywhere
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, 1, "R6 zero");
    // R7 write enables low
    step(0, 5, 5, 5, 0, 1, 5, 0, 5, 0, "R7 we low");
    // R12 independent operands
    step(0, 6, 8, 6, 1, 0, 8, 1, 0, 0, "R12");
    // R8 load-use then R9 forward from MEM/WB
    step(0, 2, 4, 4, 1, 1, 0, 0, 0, 0, "R8 load-use");
    step(0, 2, 4, 0, 0, 0, 4, 1, 0, 0, "R9 after stall");
    step(0, 4, 4, 4, 1, 1, 3, 1, 0, 0, "R8 both ops");
    step(0, 4, 4, 0, 0, 0, 4, 1, 0, 0, "R9 both ops");
    // R10 same-cycle bypass
    step(0, 12, 3, 0, 0, 0, 0, 0, 12, 1, "R10");
    // random mix with a small register pool to force collisions
    for (int i = 0; i < 3000; i++) begin
      step(0, REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
           REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0),
           REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "rand");
    end
    // mid-run reset R1
    step(1, 1, 1, 1, 1, 0, 1, 1, 0, 0, "R1 midrun");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule